// File: doc/BRIEF.md
# Funnel Shifter for Shifts and Rotates

This block is a single-cycle combinational shifter for a datapath word. It handles four operations on one operand: logical right shift, arithmetic right shift, rotate right and logical left shift. The amount can be anything from zero to one less than the word width. Every operation runs through the same right-shift core. The core places a high word above a low word to make a double-width value, shifts that value right by an amount, and keeps the low word of the result.

A small front end sets up the high word, the low word and the core's amount from the operation code. Each kind of shift is just a different set of those three values:

- **Logical right:** zeros go above the operand.
- **Arithmetic right:** sign copies go above the operand.
- **Rotate right:** the operand goes in both halves.
- **Logical left:** the operand goes above a zero word, and the core shifts right by the width minus the requested amount.

The core is a cascade of 2:1 multiplexer levels, one level for each bit of the amount. The largest step comes first, and each level is only as wide as the bits that can still reach the result.

Top module: `funnel_shifter`

## Requirements
- R1: With op = 2'b00 (logical right), res_o equals a_i shifted right by amt_i, with zeros in the vacated top bits.
- R2: With op = 2'b01 (arithmetic right), res_o equals a_i shifted right by amt_i, with every vacated top bit equal to a_i[W-1].
- R3: With op = 2'b10 (rotate right), res_o equals a_i rotated right by amt_i, so the bits leaving at the bottom re-enter at the top.
- R4: With op = 2'b11 (logical left), res_o equals a_i shifted left by amt_i, with zeros in the vacated low bits.
- R5: When amt_i is zero, res_o equals a_i for every operation code.
- R6: Every amount from 0 to W-1 is honoured for each operation, including the maximum W-1 (for example, a logical right shift by W-1 leaves only a_i[W-1] in bit 0).
- R7: The block is purely combinational, so res_o follows a change of a_i, op_i or amt_i without waiting for any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W (32) | Operand to be shifted or rotated |
| op_i | input | 2 | Operation: 00 logical right, 01 arithmetic right, 10 rotate right, 11 logical left |
| amt_i | input | log2(W) (5) | Shift or rotate amount |
| res_o | output | W (32) | Result word |

## Verification
Each operation is tried at every amount from zero to the maximum on several operand patterns:

- **All ones and all zeros:** these expose fill errors, since they leave either every vacated bit or none of them visible.
- **Words with only the sign bit or the low bit set:** these show whether the single bit travels the right distance and which fill enters behind it.
- **A positive value with the top bit clear and an irregular mixed pattern:** these separate arithmetic from logical fill, and rotation from plain shifting.

Separate directed cases change the inputs between clock edges to show that no register sits on the path.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

  typedef enum logic [1:0] {
    FSH_SRL = 2'b00,
    FSH_SRA = 2'b01,
    FSH_ROR = 2'b10,
    FSH_SLL = 2'b11
  } fsh_op_e;

endpackage

// File: rtl/fsh_operand_setup.sv
// Front end: chooses the high word, low word and core amount per operation.
module fsh_operand_setup
  import fsh_pkg::*;
#(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  a_i,
  input  fsh_op_e       op_i,
  input  logic [SW-1:0] amt_i,
  output logic [W-2:0]  hi_o,
  output logic [W-1:0]  lo_o,
  output logic [SW-1:0] camt_o
);

  logic amt_zero;
  assign amt_zero = (amt_i == '0);

  always_comb begin
    hi_o   = '0;
    lo_o   = a_i;
    camt_o = amt_i;
    unique case (op_i)
      FSH_SRL: begin
        hi_o = '0;
        lo_o = a_i;
      end
      FSH_SRA: begin
        hi_o = {(W-1){a_i[W-1]}};
        lo_o = a_i;
      end
      FSH_ROR: begin
        hi_o = a_i[W-2:0];
        lo_o = a_i;
      end
      FSH_SLL: begin
        // right amount = W - i (mod W); i = 0 bypasses with the operand below
        hi_o   = a_i[W-2:0];
        lo_o   = amt_zero ? a_i : '0;
        camt_o = (~amt_i) + 1'b1;
      end
      default: begin
        hi_o = '0;
        lo_o = a_i;
      end
    endcase
  end

endmodule

// File: rtl/fsh_mux_stage.sv
// One level of the cascade: shift right by DIST or pass, dropping dead top bits.
module fsh_mux_stage #(
  parameter int IW   = 63,
  parameter int DIST = 16,
  localparam int OW  = IW - DIST
) (
  input  logic [IW-1:0] din,
  input  logic          sel,
  output logic [OW-1:0] dout
);

  assign dout = sel ? din[IW-1:DIST] : din[OW-1:0];

endmodule

// File: rtl/fsh_core.sv
// Extracts W bits from the (2W-1)-bit window {hi, lo} shifted right by camt.
module fsh_core #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-2:0]  hi_i,
  input  logic [W-1:0]  lo_i,
  input  logic [SW-1:0] camt_i,
  output logic [W-1:0]  win_o
);

  localparam int XW = 2*W - 1;

  logic [XW-1:0] ext;
  assign ext = {hi_i, lo_i};

  for (genvar j = 0; j < SW; j++) begin : g_lvl
    localparam int B    = SW - 1 - j;
    localparam int DIST = 1 << B;
    localparam int IW   = W - 1 + (1 << (SW - j));
    localparam int OW   = W - 1 + DIST;
    logic [IW-1:0] din;
    logic [OW-1:0] dout;
    if (j == 0) begin : g_first
      assign din = ext;
    end else begin : g_next
      assign din = g_lvl[j-1].dout;
    end
    fsh_mux_stage #(.IW(IW), .DIST(DIST)) u_stage (
      .din (din),
      .sel (camt_i[B]),
      .dout(dout)
    );
  end

  assign win_o = g_lvl[SW-1].dout;

endmodule

// File: rtl/funnel_shifter.sv
module funnel_shifter
  import fsh_pkg::*;
#(
  parameter int W   = 32,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  a_i,
  input  logic [1:0]    op_i,
  input  logic [SW-1:0] amt_i,
  output logic [W-1:0]  res_o
);

  fsh_op_e       op;
  logic [W-2:0]  hi;
  logic [W-1:0]  lo;
  logic [SW-1:0] camt;

  assign op = fsh_op_e'(op_i);

  fsh_operand_setup #(.W(W), .SW(SW)) u_setup (
    .a_i   (a_i),
    .op_i  (op),
    .amt_i (amt_i),
    .hi_o  (hi),
    .lo_o  (lo),
    .camt_o(camt)
  );

  fsh_core #(.W(W), .SW(SW)) u_core (
    .hi_i  (hi),
    .lo_i  (lo),
    .camt_i(camt),
    .win_o (res_o)
  );

  always_comb begin
    if (amt_i == '0) begin
      // R5
      zero_amt_pass_chk: assert (res_o == a_i);
    end
    if (op == FSH_SRL && amt_i != '0) begin
      // R1
      srl_top_zero_chk: assert (res_o[W-1] == 1'b0);
    end
    if (op == FSH_SRA) begin
      // R2
      sra_sign_keep_chk: assert (res_o[W-1] == a_i[W-1]);
    end
    if (op == FSH_ROR) begin
      // R3
      ror_ones_kept_chk: assert ($countones(res_o) == $countones(a_i));
    end
    if (op == FSH_SLL && amt_i != '0) begin
      // R4
      sll_low_zero_chk: assert (res_o[0] == 1'b0);
    end
  end

endmodule

// File: tb/funnel_shifter_test.sv
`timescale 1ns/1ps
module funnel_shifter_test;

  localparam int W  = 32;
  localparam int SW = 5;

  logic          clk;
  logic          rst_n;
  logic [W-1:0]  a;
  logic [1:0]    op;
  logic [SW-1:0] amt;
  logic [W-1:0]  res;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  funnel_shifter #(.W(W)) uut (
    .a_i  (a),
    .op_i (op),
    .amt_i(amt),
    .res_o(res)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000) begin
      fails = fails + 1;
      $display("FAIL R7 watchdog expired actual=%0d expected<=50000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  logic [W-1:0] pats [6];
  initial begin
    pats[0] = 32'hFFFF_FFFF;
    pats[1] = 32'h0000_0000;
    pats[2] = 32'h8000_0000;
    pats[3] = 32'h0000_0001;
    pats[4] = 32'h7FFF_FFFF;
    pats[5] = 32'hA5C3_1E69;
  end

  function automatic logic [W-1:0] model(input logic [1:0] o, input logic [W-1:0] x,
                                         input int s);
    case (o)
      2'b00:   model = x >> s;
      2'b01:   model = W'($signed(x) >>> s);
      2'b10:   model = (s == 0) ? x : ((x >> s) | (x << (W - s)));
      default: model = x << s;
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s op=%0d amt=%0d a=%h actual=%h expected=%h", req, op, amt, a, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] o, input logic [W-1:0] x, input int s);
    @(negedge clk);
    op  = o;
    a   = x;
    amt = SW'(s);
    #2;
  endtask

  task automatic sweep_op(input logic [1:0] o, input string req);
    for (int p = 0; p < 6; p++) begin
      for (int s = 0; s < W; s++) begin
        apply(o, pats[p], s);
        check(req, res, model(o, pats[p], s));
      end
    end
  endtask

  task automatic test_reset_state;
    rst_n = 1'b0;
    op = 2'b00; a = '0; amt = '0;
    #3;
    check("R7 reset", res, 32'h0);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
  endtask

  task automatic test_srl;  sweep_op(2'b00, "R1"); endtask
  task automatic test_sra;  sweep_op(2'b01, "R2"); endtask
  task automatic test_ror;  sweep_op(2'b10, "R3"); endtask
  task automatic test_sll;  sweep_op(2'b11, "R4"); endtask

  task automatic test_zero_amount;
    for (int o = 0; o < 4; o++) begin
      apply(2'(o), 32'hDEAD_BEEF, 0);
      check("R5", res, 32'hDEAD_BEEF);
    end
  endtask

  task automatic test_max_amount;
    apply(2'b00, 32'h8000_0000, 31); check("R6 srl max", res, 32'h0000_0001);
    apply(2'b01, 32'h8000_0000, 31); check("R6 sra max", res, 32'hFFFF_FFFF);
    apply(2'b10, 32'h0000_0001, 31); check("R6 ror max", res, 32'h0000_0002);
    apply(2'b11, 32'h0000_0003, 31); check("R6 sll max", res, 32'h8000_0000);
  endtask

  task automatic test_no_latency;
    @(negedge clk);
    op = 2'b10; a = 32'h1234_5678; amt = 5'd4;
    #1;
    check("R7 same-time", res, 32'h8123_4567);
    amt = 5'd8;
    #1;
    check("R7 amt change", res, 32'h7812_3456);
    op = 2'b11;
    #1;
    check("R7 op change", res, 32'h3456_7800);
  endtask

  initial begin
    test_reset_state();
    test_srl();
    test_sra();
    test_ror();
    test_sll();
    test_zero_amount();
    test_max_amount();
    test_no_latency();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule